// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host with a narrow 16-bit bus and a 3-bit direct address reach a much larger internal register space. The internal space is addressed by 16 bits and holds 32-bit words. The host first places the two 16-bit halves of a word into holding registers. It then points the bridge at an internal location and commits the word. A readback of the selected location comes back as two separate 16-bit reads. A status word and an output-data port also sit in the direct window.

The host strobes are treated as asynchronous to the core clock. Each one passes through a multi-stage synchronizer before it can touch a holding register or produce a commit. A commit reaches the core as a single one-clock pulse, however long the host holds its write strobe. The data-port read works the same way: when a read of that port ends, the core receives a single one-clock advance pulse.

Top module: `ind_reg_bridge`

## Requirements
- R1: While `host_rd` and `host_cs` are high, direct address 0 returns `core_rdata[15:0]` and direct address 1 returns `core_rdata[31:16]`. `core_rdata` is the word at the location currently on `core_addr`.
- R2: While `host_rd` and `host_cs` are high, direct address 3 returns the status register. This register holds the value `core_status` had one clock earlier.
- R3: While `host_rd` and `host_cs` are high, direct address 2 returns `fifo_data`. When a read of address 2 ends, `fifo_pop` goes high for exactly one clock, after synchronization. Reads at any other address never pulse `fifo_pop`.
- R4: `host_rdata` is zero whenever `host_rd` or `host_cs` is low, and for direct addresses 4 to 7.
- R5: A write at direct address 0 loads bits 15:0 of `core_wdata`. A write at direct address 1 loads bits 31:16. Neither write produces a commit pulse.
- R6: A write at direct address 3 loads `core_addr` from the write data. It then issues a commit pulse that carries the held 32-bit word to that new location.
- R7: A write at direct address 2 issues a commit pulse to the unchanged `core_addr`. The holding registers are left as they were.
- R8: Each host write strobe that needs a commit produces exactly one `core_wr_pulse`, one clock wide. This holds whatever the length of the strobe.
- R9: A write with `host_cs` low, or at direct addresses 4 to 7, changes neither `core_addr` nor `core_wdata` and produces no pulse.
- R10: A synchronous reset clears `core_addr`, both holding halves and the status register. It also cancels any commit or advance pulse still inside the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host chip enable, active high |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_wr | input | 1 | Host write strobe, active high, asynchronous |
| host_addr | input | 3 | Direct address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational |
| core_addr | output | 16 | Selected internal location |
| core_wdata | output | 32 | Held 32-bit write word |
| core_wr_pulse | output | 1 | One-clock commit to `core_addr` |
| core_rdata | input | 32 | Word read from `core_addr` |
| core_status | input | 16 | Status flags from the core |
| fifo_data | input | 16 | Current output-data word |
| fifo_pop | output | 1 | One-clock advance after a data-port read |

## Verification
The main write path is driven with several command patterns. These include a half load followed by a commit through the address location, a commit through the data-port location that keeps the old target, and a retarget that reuses the stale held word. Each pattern separates the two commit paths by checking whether `core_addr` moved and which location the scoreboard sees written. Writes with the chip enable low or to unmapped addresses show whether the decoder really ignores them. A strobe held for many clocks separates an edge detector from a level detector. A reset asserted while a strobe is still in the synchronizer shows whether pulses already in flight are cancelled.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int DADDR_W = 3;

  typedef enum logic [DADDR_W-1:0] {
    SEL_LO   = 3'd0,
    SEL_HI   = 3'd1,
    SEL_PORT = 3'd2,
    SEL_CTRL = 3'd3
  } dsel_e;
endpackage

// File: rtl/ibr_strobe_sync.sv
module ibr_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_q,
  output logic sync_d
);
  localparam int CHAIN_W = (STAGES < 1) ? 1 : STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (CHAIN_W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sync_d <= 1'b0;
    else     sync_d <= chain[CHAIN_W-1];
  end

  assign sync_q = chain[CHAIN_W-1];
endmodule

// File: rtl/ibr_write_capture.sv
module ibr_write_capture
  import ibr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_q,
  input  logic               wr_d,
  input  logic               host_cs,
  input  logic [DADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  hold_lo,
  output logic [DATA_W-1:0]  hold_hi,
  output logic [IADDR_W-1:0] ind_addr,
  output logic               commit
);
  logic  wr_evt;
  dsel_e sel;

  assign wr_evt = wr_q & ~wr_d & host_cs;
  assign sel    = dsel_e'(host_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_lo  <= '0;
      hold_hi  <= '0;
      ind_addr <= '0;
      commit   <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (wr_evt) begin
        case (sel)
          SEL_LO:   hold_lo <= host_wdata;
          SEL_HI:   hold_hi <= host_wdata;
          SEL_PORT: commit  <= 1'b1;
          SEL_CTRL: begin
            ind_addr <= IADDR_W'(host_wdata);
            commit   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ibr_read_port.sv
module ibr_read_port
  import ibr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_q,
  input  logic                rd_d,
  input  logic                host_cs,
  input  logic                host_rd,
  input  logic [DADDR_W-1:0]  host_addr,
  input  logic [2*DATA_W-1:0] core_rdata,
  input  logic [DATA_W-1:0]   core_status,
  input  logic [DATA_W-1:0]   fifo_data,
  output logic [DATA_W-1:0]   host_rdata,
  output logic                fifo_pop
);
  logic [DATA_W-1:0] status_q;
  logic              port_armed;
  logic              rd_rise;
  logic              rd_fall;
  dsel_e             sel;

  assign sel     = dsel_e'(host_addr);
  assign rd_rise = rd_q & ~rd_d;
  assign rd_fall = ~rd_q & rd_d;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= core_status;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_armed <= 1'b0;
      fifo_pop   <= 1'b0;
    end else begin
      fifo_pop <= 1'b0;
      if (rd_rise) begin
        port_armed <= host_cs && (sel == SEL_PORT);
      end else if (rd_fall) begin
        fifo_pop   <= port_armed;
        port_armed <= 1'b0;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_rd && host_cs) begin
      case (sel)
        SEL_LO:   host_rdata = core_rdata[DATA_W-1:0];
        SEL_HI:   host_rdata = core_rdata[2*DATA_W-1:DATA_W];
        SEL_PORT: host_rdata = fifo_data;
        SEL_CTRL: host_rdata = status_q;
        default:  host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int IADDR_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_cs,
  input  logic                host_rd,
  input  logic                host_wr,
  input  logic [DADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  output logic [IADDR_W-1:0]  core_addr,
  output logic [2*DATA_W-1:0] core_wdata,
  output logic                core_wr_pulse,
  input  logic [2*DATA_W-1:0] core_rdata,
  input  logic [DATA_W-1:0]   core_status,
  input  logic [DATA_W-1:0]   fifo_data,
  output logic                fifo_pop
);
  logic              wr_q, wr_d;
  logic              rd_q, rd_d;
  logic [DATA_W-1:0] hold_lo, hold_hi;

  ibr_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (host_wr),
    .sync_q   (wr_q),
    .sync_d   (wr_d)
  );

  ibr_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (host_rd),
    .sync_q   (rd_q),
    .sync_d   (rd_d)
  );

  ibr_write_capture #(.DATA_W(DATA_W), .IADDR_W(IADDR_W)) u_wcap (
    .clk        (clk),
    .rst        (rst),
    .wr_q       (wr_q),
    .wr_d       (wr_d),
    .host_cs    (host_cs),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .hold_lo    (hold_lo),
    .hold_hi    (hold_hi),
    .ind_addr   (core_addr),
    .commit     (core_wr_pulse)
  );

  ibr_read_port #(.DATA_W(DATA_W)) u_rport (
    .clk         (clk),
    .rst         (rst),
    .rd_q        (rd_q),
    .rd_d        (rd_d),
    .host_cs     (host_cs),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .core_rdata  (core_rdata),
    .core_status (core_status),
    .fifo_data   (fifo_data),
    .host_rdata  (host_rdata),
    .fifo_pop    (fifo_pop)
  );

  assign core_wdata = {hold_hi, hold_lo};
endmodule

// File: rtl/ind_reg_bridge_chk.sv
module ind_reg_bridge_chk #(
  parameter int DATA_W  = 16,
  parameter int IADDR_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                host_cs,
  input logic                host_rd,
  input logic [2:0]          host_addr,
  input logic [DATA_W-1:0]   host_rdata,
  input logic [IADDR_W-1:0]  core_addr,
  input logic [2*DATA_W-1:0] core_wdata,
  input logic                core_wr_pulse,
  input logic [2*DATA_W-1:0] core_rdata,
  input logic [DATA_W-1:0]   core_status,
  input logic                fifo_pop
);
  AST_WR_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    core_wr_pulse |=> !core_wr_pulse); // R8

  AST_POP_ONE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (core_addr == '0 && core_wdata == '0 && !core_wr_pulse && !fifo_pop)); // R10

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(host_rd && host_cs) |-> host_rdata == '0); // R4

  AST_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_cs && host_addr == 3'd0) |-> host_rdata == core_rdata[DATA_W-1:0]); // R1

  AST_HIGH_HALF: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_cs && host_addr == 3'd1) |-> host_rdata == core_rdata[2*DATA_W-1:DATA_W]); // R1

  AST_STATUS_LAG: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_cs && host_addr == 3'd3 && !$past(rst)) |-> host_rdata == $past(core_status)); // R2
endmodule

bind ind_reg_bridge ind_reg_bridge_chk #(.DATA_W(DATA_W), .IADDR_W(IADDR_W)) u_chk (.*);

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_cs = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [15:0] core_addr;
  logic [31:0] core_wdata;
  logic        core_wr_pulse;
  logic [31:0] core_rdata;
  logic [15:0] core_status = '0;
  logic [15:0] fifo_data = '0;
  logic        fifo_pop;

  int total = 0;
  int bad   = 0;
  int pop_cnt = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mem [0:15];

  always #2.5 clk = ~clk;

  ind_reg_bridge u_ind_reg_bridge (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_wr_pulse(core_wr_pulse),
    .core_rdata(core_rdata), .core_status(core_status), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop)
  );

  initial for (int i = 0; i < 16; i++) mem[i] = 32'hC0DE_0000 + i;
  always @(posedge clk) if (core_wr_pulse) mem[core_addr[3:0]] <= core_wdata;
  assign core_rdata = mem[core_addr[3:0]];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each commit pulse
  always @(negedge clk) begin
    if (!rst && fifo_pop) pop_cnt++;
    if (!rst && core_wr_pulse) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 unexpected commit act=%h_%h exp=none", core_addr, core_wdata);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {core_addr, core_wdata}, e);
      end
    end
  end

  task automatic expect_commit(string tag, logic [15:0] a, logic [31:0] d);
    exp_q.push_back({a, d});
    tag_q.push_back(tag);
  endtask

  task automatic host_write(logic [2:0] a, logic [15:0] d, logic cs, int hold);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_cs = cs; host_wr = 1'b1;
    repeat (hold) @(negedge clk);
    host_wr = 1'b0;
    repeat (2) @(negedge clk);
    host_cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic host_read(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_cs = 1'b1; host_rd = 1'b1;
    #1 d = host_rdata;
    repeat (4) @(negedge clk);
    host_rd = 1'b0;
    @(negedge clk);
    host_cs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rd;
    int p0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset core_addr", core_addr, 0);
    chk("R10 reset core_wdata", core_wdata, 0);
    chk("R10 reset pulse", core_wr_pulse, 0);
    chk("R4 idle rdata", host_rdata, 0);

    // R4: read with chip enable low, and unmapped address
    host_addr = 3'd0; host_rd = 1'b1; host_cs = 1'b0;
    #1 chk("R4 cs low", host_rdata, 0);
    @(negedge clk); host_rd = 1'b0;
    host_read(3'd5, rd); chk("R4 addr 5", rd, 0);

    // R5: holding halves
    host_write(3'd0, 16'h1234, 1'b1, 5);
    chk("R5 low half", core_wdata, 32'h0000_1234);
    host_write(3'd1, 16'hABCD, 1'b1, 5);
    chk("R5 high half", core_wdata, 32'hABCD_1234);

    // R6: set address and commit
    expect_commit("R6 commit via addr", 16'h0005, 32'hABCD_1234);
    host_write(3'd3, 16'h0005, 1'b1, 5);
    chk("R6 core_addr", core_addr, 16'h0005);
    host_read(3'd0, rd); chk("R1 low readback", rd, 16'h1234);
    host_read(3'd1, rd); chk("R1 high readback", rd, 16'hABCD);

    // R7: commit through data-port location
    host_write(3'd0, 16'hAAAA, 1'b1, 5);
    host_write(3'd1, 16'h5555, 1'b1, 5);
    expect_commit("R7 commit same addr", 16'h0005, 32'h5555_AAAA);
    host_write(3'd2, 16'hFFFF, 1'b1, 5);
    chk("R7 addr kept", core_addr, 16'h0005);
    chk("R7 hold kept", core_wdata, 32'h5555_AAAA);
    host_read(3'd1, rd); chk("R1 high after R7", rd, 16'h5555);

    // R9: ignored writes
    host_write(3'd0, 16'h7777, 1'b0, 5);
    host_write(3'd6, 16'h8888, 1'b1, 5);
    host_write(3'd3, 16'h0009, 1'b0, 5);
    chk("R9 hold unchanged", core_wdata, 32'h5555_AAAA);
    chk("R9 addr unchanged", core_addr, 16'h0005);

    // R6: retarget reusing held word
    expect_commit("R6 retarget", 16'h0009, 32'h5555_AAAA);
    host_write(3'd3, 16'h0009, 1'b1, 5);
    host_read(3'd0, rd); chk("R1 low at 9", rd, 16'hAAAA);

    // R8: long strobe gives one pulse
    expect_commit("R8 long strobe", 16'h0009, 32'h5555_AAAA);
    host_write(3'd2, 16'h0000, 1'b1, 25);

    // R2: status readback
    @(negedge clk); core_status = 16'h3C5A;
    host_read(3'd3, rd); chk("R2 status", rd, 16'h3C5A);

    // R3: data port and advance pulse
    fifo_data = 16'hBEEF;
    p0 = pop_cnt;
    host_read(3'd2, rd); chk("R3 port data", rd, 16'hBEEF);
    chk("R3 one pop", pop_cnt, p0 + 1);
    host_read(3'd1, rd);
    chk("R3 no pop elsewhere", pop_cnt, p0 + 1);

    // R10: reset while a commit is in the synchronizer
    @(negedge clk);
    host_addr = 3'd3; host_wdata = 16'h000B; host_cs = 1'b1; host_wr = 1'b1;
    @(negedge clk);
    rst = 1'b1; host_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; host_cs = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 addr cleared", core_addr, 0);
    chk("R10 hold cleared", core_wdata, 0);

    chk("R8 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule